// File: doc/BRIEF.md
# Serial EEPROM Byte Access Sequencer

This block sits between a simple host request port and a serial EEPROM on an SPI bus, acting as the bus master. The host presents one byte-write or one byte-read at a time. A write becomes three kinds of chip-select frame: a write-enable instruction alone in its own frame, then the write instruction carrying a 16-bit address and the data byte, then a loop of status-register reads. The loop repeats until the device reports that its internal write cycle has finished. A read becomes a single frame: the read instruction, the address, and eight clocked-in data bits.

The serial clock follows mode 0: it idles low, data leaves on the falling edge and is sampled on the rising edge. Its half period is computed at elaboration from the system clock frequency and the highest serial clock the part allows. Between frames, chip select stays high for a set number of system clocks. Status polling is bounded. If the busy flag is still set after a set number of polls, the request ends with a timeout flag. The write-protect pin is released only while a write request is in progress.

Top module: `eeprom_wr_sequencer`

## Requirements
- R1: After reset spi_cs_n is 1, spi_sck is 0, spi_wp_n is 0, and busy, done and timeout_err are 0.
- R2: A request (req high on a clock edge) is taken only while busy is 0. A req pulse while busy is 1 starts no frame and changes no result.
- R3: A write (we=1) sends opcode 0x06 as an 8-bit frame of its own. It then sends, in a new frame, opcode 0x02, the 16-bit address and the data byte, each MSB first (32 bits).
- R4: After the write frame, 16-bit status frames (opcode 0x05, then 8 bits read back) repeat until status bit 0 (write in progress) reads 0. done is raised only after that. A read request sends no status frame.
- R5: A read (we=0) sends opcode 0x03 and the 16-bit address MSB first, then samples 8 bits on spi_miso, MSB first, at the next 8 rising edges of spi_sck. The resulting byte appears on rdata together with done.
- R6: spi_sck is 0 whenever spi_cs_n is 1. spi_mosi only changes while spi_sck is low.
- R7: Every high and low phase of spi_sck within a frame lasts exactly ceil(CLK_HZ / (2*SCK_MAX_HZ)) system clocks.
- R8: Between two frames of one request, spi_cs_n stays high for at least CS_GAP system clocks.
- R9: If MAX_POLLS status frames in a row all report bit 0 set, the request ends with done and timeout_err both 1, and the block returns to idle. timeout_err stays 1 until the next request is taken.
- R10: busy is 1 from the edge that takes a request until the cycle of done. done is a single-cycle pulse, raised in the cycle where busy returns to 0.
- R11: spi_wp_n is 1 only while a write request is busy and is 0 at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req | input | 1 | Request strobe, taken when idle |
| we | input | 1 | 1 = byte write, 0 = byte read |
| addr | input | 16 | Byte address |
| wdata | input | 8 | Byte to write |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Byte returned by the last read |
| timeout_err | output | 1 | Last request gave up polling |
| spi_sck | output | 1 | Serial clock, mode 0 |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data to the EEPROM |
| spi_miso | input | 1 | Serial data from the EEPROM |
| spi_wp_n | output | 1 | Write protect, active low |

## Verification
The bench builds the block with CLK_HZ = 200 MHz and SCK_MAX_HZ = 25 MHz, which gives a four-cycle half period and keeps each frame short. CS_GAP is 3, so the gap can be measured exactly. MAX_POLLS is 4, so an EEPROM model that stays busy for many polls reaches the timeout within a few frames. The same setting lets a write that clears on the last allowed poll sit right at the boundary and still complete. The model answers status polls with a programmable number of busy replies and only commits writes that follow a write-enable frame with write-protect released.

// File: rtl/spi_seq_pkg.sv
// Package: shared constants and state type for the EEPROM sequencer.
// Assumes a device with 16-bit addressing and standard instruction codes.
package spi_seq_pkg;
    localparam int ADDR_W  = 16;
    localparam int DATA_W  = 8;
    localparam int OPC_W   = 8;
    localparam int FRAME_W = OPC_W + ADDR_W + DATA_W;
    localparam int BIT_W   = $clog2(FRAME_W + 1);

    localparam logic [OPC_W-1:0] OPC_WR_ENABLE = 8'h06;
    localparam logic [OPC_W-1:0] OPC_WR_BYTE   = 8'h02;
    localparam logic [OPC_W-1:0] OPC_RD_BYTE   = 8'h03;
    localparam logic [OPC_W-1:0] OPC_RD_STATUS = 8'h05;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WREN,
        ST_WRITE,
        ST_POLL,
        ST_READ,
        ST_GAP
    } seq_state_t;
endpackage

// File: rtl/sck_half_timer.sv
// Module: sck_half_timer
// Emits a one-cycle tick every HALF system clocks while run is high.
// Assumes HALF >= 1; the count restarts from zero whenever run is low.
module sck_half_timer #(
    parameter int HALF = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CNT_W = $clog2(HALF + 1);

    logic [CNT_W-1:0] cnt_q;

    assign tick = run && (cnt_q == CNT_W'(HALF - 1));

    // Count system clocks within one serial clock phase.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/spi_frame_engine.sv
// Module: spi_frame_engine
// Shifts out up to FRAME_W bits MSB first in SPI mode 0 and captures the
// last DATA_W bits seen on miso at the rising edges. Chip select is owned
// by the caller; start is ignored while a frame is running.
module spi_frame_engine
    import spi_seq_pkg::*;
#(
    parameter int HALF = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [FRAME_W-1:0] tx_frame,
    input  logic [BIT_W-1:0]   nbits,
    input  logic               miso,
    output logic               sck,
    output logic               mosi,
    output logic [DATA_W-1:0]  rx_byte,
    output logic               frame_done
);
    logic               active_q;
    logic               phase_hi_q;
    logic [FRAME_W-1:0] shreg_q;
    logic [BIT_W-1:0]   left_q;
    logic [DATA_W-1:0]  rx_q;
    logic               done_q;
    logic               tick;

    sck_half_timer #(.HALF(HALF)) i_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (active_q),
        .tick  (tick)
    );

    // Walk the bit phases: sample on the rise, shift on the fall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q   <= 1'b0;
            phase_hi_q <= 1'b0;
            shreg_q    <= '0;
            left_q     <= '0;
            rx_q       <= '0;
            done_q     <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (!active_q) begin
                if (start) begin
                    active_q   <= 1'b1;
                    phase_hi_q <= 1'b0;
                    shreg_q    <= tx_frame;
                    left_q     <= nbits;
                end
            end else if (tick) begin
                if (!phase_hi_q) begin
                    phase_hi_q <= 1'b1;
                    rx_q       <= {rx_q[DATA_W-2:0], miso};
                end else begin
                    phase_hi_q <= 1'b0;
                    shreg_q    <= {shreg_q[FRAME_W-2:0], 1'b0};
                    if (left_q == BIT_W'(1)) begin
                        active_q <= 1'b0;
                        done_q   <= 1'b1;
                    end else begin
                        left_q <= left_q - 1'b1;
                    end
                end
            end
        end
    end

    assign sck        = phase_hi_q;
    assign mosi       = shreg_q[FRAME_W-1];
    assign rx_byte    = rx_q;
    assign frame_done = done_q;
endmodule

// File: rtl/eeprom_wr_sequencer.sv
// Module: eeprom_wr_sequencer (top)
// Turns single-byte host requests into serial EEPROM frames. A write runs
// enable, write and bounded status polling; a read runs one frame. Assumes
// CS_GAP >= 1, MAX_POLLS >= 1 and SCK_MAX_HZ <= CLK_HZ / 2.
module eeprom_wr_sequencer
    import spi_seq_pkg::*;
#(
    parameter int CLK_HZ     = 100_000_000,
    parameter int SCK_MAX_HZ = 10_000_000,
    parameter int CS_GAP     = 4,
    parameter int MAX_POLLS  = 1000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req,
    input  logic        we,
    input  logic [15:0] addr,
    input  logic [7:0]  wdata,
    output logic        busy,
    output logic        done,
    output logic [7:0]  rdata,
    output logic        timeout_err,
    output logic        spi_sck,
    output logic        spi_cs_n,
    output logic        spi_mosi,
    input  logic        spi_miso,
    output logic        spi_wp_n
);
    localparam int HALF   = (CLK_HZ + 2 * SCK_MAX_HZ - 1) / (2 * SCK_MAX_HZ);
    localparam int GAP_W  = $clog2(CS_GAP + 1);
    localparam int POLL_W = $clog2(MAX_POLLS + 1);

    seq_state_t         state_q;
    seq_state_t         next_q;
    seq_state_t         launch_kind;
    logic               op_we_q;
    logic [ADDR_W-1:0]  op_addr_q;
    logic [DATA_W-1:0]  op_data_q;
    logic [ADDR_W-1:0]  addr_sel;
    logic [DATA_W-1:0]  data_sel;
    logic [GAP_W-1:0]   gap_q;
    logic [POLL_W-1:0]  poll_q;
    logic               cs_n_q;
    logic               start_q;
    logic [FRAME_W-1:0] tx_q;
    logic [BIT_W-1:0]   bits_q;
    logic [FRAME_W-1:0] launch_tx;
    logic [BIT_W-1:0]   launch_bits;
    logic               done_q;
    logic [DATA_W-1:0]  rdata_q;
    logic               tmo_q;
    logic               tmo_pend_q;
    logic [DATA_W-1:0]  rx_byte;
    logic               frame_done;

    spi_frame_engine #(.HALF(HALF)) i_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start_q),
        .tx_frame   (tx_q),
        .nbits      (bits_q),
        .miso       (spi_miso),
        .sck        (spi_sck),
        .mosi       (spi_mosi),
        .rx_byte    (rx_byte),
        .frame_done (frame_done)
    );

    // Pick the next frame and build its bit image.
    always_comb begin
        launch_kind = (state_q == ST_IDLE) ? (we ? ST_WREN : ST_READ) : next_q;
        addr_sel    = (state_q == ST_IDLE) ? addr  : op_addr_q;
        data_sel    = (state_q == ST_IDLE) ? wdata : op_data_q;
        launch_tx   = '0;
        launch_bits = '0;
        case (launch_kind)
            ST_WREN: begin
                launch_tx   = {OPC_WR_ENABLE, {(FRAME_W-OPC_W){1'b0}}};
                launch_bits = BIT_W'(OPC_W);
            end
            ST_WRITE: begin
                launch_tx   = {OPC_WR_BYTE, addr_sel, data_sel};
                launch_bits = BIT_W'(FRAME_W);
            end
            ST_READ: begin
                launch_tx   = {OPC_RD_BYTE, addr_sel, {DATA_W{1'b0}}};
                launch_bits = BIT_W'(FRAME_W);
            end
            ST_POLL: begin
                launch_tx   = {OPC_RD_STATUS, {(FRAME_W-OPC_W){1'b0}}};
                launch_bits = BIT_W'(OPC_W + DATA_W);
            end
            default: begin
                launch_tx   = '0;
                launch_bits = '0;
            end
        endcase
    end

    // Request sequencing: frames, chip-select gaps, polling and completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            next_q     <= ST_IDLE;
            op_we_q    <= 1'b0;
            op_addr_q  <= '0;
            op_data_q  <= '0;
            gap_q      <= '0;
            poll_q     <= '0;
            cs_n_q     <= 1'b1;
            start_q    <= 1'b0;
            tx_q       <= '0;
            bits_q     <= '0;
            done_q     <= 1'b0;
            rdata_q    <= '0;
            tmo_q      <= 1'b0;
            tmo_pend_q <= 1'b0;
        end else begin
            start_q <= 1'b0;
            done_q  <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (req) begin
                        op_we_q    <= we;
                        op_addr_q  <= addr;
                        op_data_q  <= wdata;
                        tmo_q      <= 1'b0;
                        tmo_pend_q <= 1'b0;
                        poll_q     <= '0;
                        state_q    <= launch_kind;
                        cs_n_q     <= 1'b0;
                        start_q    <= 1'b1;
                        tx_q       <= launch_tx;
                        bits_q     <= launch_bits;
                    end
                end
                ST_WREN: begin
                    if (frame_done) begin
                        cs_n_q  <= 1'b1;
                        gap_q   <= '0;
                        next_q  <= ST_WRITE;
                        state_q <= ST_GAP;
                    end
                end
                ST_WRITE: begin
                    if (frame_done) begin
                        cs_n_q  <= 1'b1;
                        gap_q   <= '0;
                        poll_q  <= '0;
                        next_q  <= ST_POLL;
                        state_q <= ST_GAP;
                    end
                end
                ST_POLL: begin
                    if (frame_done) begin
                        cs_n_q  <= 1'b1;
                        gap_q   <= '0;
                        state_q <= ST_GAP;
                        if (!rx_byte[0]) begin
                            next_q <= ST_IDLE;
                        end else if (poll_q == POLL_W'(MAX_POLLS - 1)) begin
                            next_q     <= ST_IDLE;
                            tmo_pend_q <= 1'b1;
                        end else begin
                            poll_q <= poll_q + 1'b1;
                            next_q <= ST_POLL;
                        end
                    end
                end
                ST_READ: begin
                    if (frame_done) begin
                        cs_n_q  <= 1'b1;
                        gap_q   <= '0;
                        rdata_q <= rx_byte;
                        next_q  <= ST_IDLE;
                        state_q <= ST_GAP;
                    end
                end
                ST_GAP: begin
                    if (gap_q == GAP_W'(CS_GAP - 1)) begin
                        if (next_q == ST_IDLE) begin
                            state_q <= ST_IDLE;
                            done_q  <= 1'b1;
                            tmo_q   <= tmo_pend_q;
                        end else begin
                            state_q <= next_q;
                            cs_n_q  <= 1'b0;
                            start_q <= 1'b1;
                            tx_q    <= launch_tx;
                            bits_q  <= launch_bits;
                        end
                    end else begin
                        gap_q <= gap_q + 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy        = (state_q != ST_IDLE);
    assign done        = done_q;
    assign rdata       = rdata_q;
    assign timeout_err = tmo_q;
    assign spi_cs_n    = cs_n_q;
    assign spi_wp_n    = busy && op_we_q;
endmodule

// File: rtl/eeprom_seq_checker.sv
// Module: eeprom_seq_checker
// Protocol and handshake properties of the sequencer, bound to its top.
// Assumes the synchronous active-low reset of the top.
module eeprom_seq_checker #(
    parameter int CS_GAP = 4
) (
    input logic clk,
    input logic rst_n,
    input logic req,
    input logic busy,
    input logic done,
    input logic timeout_err,
    input logic spi_sck,
    input logic spi_cs_n,
    input logic spi_mosi,
    input logic spi_wp_n
);
    int hi_run;

    // Count cycles chip select has been high, saturating at CS_GAP.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_run <= CS_GAP;
        end else if (spi_cs_n) begin
            if (hi_run < CS_GAP) hi_run <= hi_run + 1;
        end else begin
            hi_run <= 0;
        end
    end

    assert_sck_idle_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sck);

    assert_mosi_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        spi_sck |-> $stable(spi_mosi));

    assert_cs_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(spi_cs_n) |-> (hi_run >= CS_GAP));

    assert_take_when_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !req) |=> !busy);

    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_cs_in_request_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !spi_cs_n |-> busy);

    assert_wp_only_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        spi_wp_n |-> busy);

    assert_timeout_with_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_err) |-> done);
endmodule

bind eeprom_wr_sequencer eeprom_seq_checker #(.CS_GAP(CS_GAP)) i_seq_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req         (req),
    .busy        (busy),
    .done        (done),
    .timeout_err (timeout_err),
    .spi_sck     (spi_sck),
    .spi_cs_n    (spi_cs_n),
    .spi_mosi    (spi_mosi),
    .spi_wp_n    (spi_wp_n)
);

// File: tb/test_eeprom_wr_sequencer.sv
`timescale 1ns/1ps
module test_eeprom_wr_sequencer;
    localparam int CLK_HZ    = 200_000_000;
    localparam int SCK_HZ    = 25_000_000;
    localparam int CS_GAP    = 3;
    localparam int MAX_POLLS = 4;
    localparam int HALF_EXP  = (CLK_HZ + 2 * SCK_HZ - 1) / (2 * SCK_HZ);

    typedef struct packed {
        logic        we;
        logic [15:0] addr;
        logic [7:0]  data;
        logic [7:0]  busy_replies;
    } vec_t;

    localparam vec_t VEC [0:5] = '{
        '{1'b1, 16'h1234, 8'hA5, 8'd2},
        '{1'b0, 16'h1234, 8'hA5, 8'd0},
        '{1'b1, 16'h00FF, 8'h3C, 8'd0},
        '{1'b0, 16'h00FF, 8'h3C, 8'd0},
        '{1'b1, 16'hBEEF, 8'h77, 8'(MAX_POLLS - 1)},
        '{1'b0, 16'hBEEF, 8'h77, 8'd0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        we = 1'b0;
    logic [15:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic        busy, done, timeout_err;
    logic [7:0]  rdata;
    logic        spi_sck, spi_cs_n, spi_mosi, spi_wp_n;
    logic        spi_miso = 1'b0;

    int n_checks = 0;
    int n_fails  = 0;

    always #2.5 clk = ~clk;

    eeprom_wr_sequencer #(
        .CLK_HZ(CLK_HZ), .SCK_MAX_HZ(SCK_HZ),
        .CS_GAP(CS_GAP), .MAX_POLLS(MAX_POLLS)
    ) i_eeprom_wr_sequencer (
        .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr),
        .wdata(wdata), .busy(busy), .done(done), .rdata(rdata),
        .timeout_err(timeout_err), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_wp_n(spi_wp_n)
    );

    // ---------------- EEPROM model ----------------
    int          m_cnt = 0;
    logic [31:0] m_shift = '0;
    logic [7:0]  m_op = '0;
    logic [15:0] m_addr = '0;
    logic [7:0]  mem [0:255];
    logic        wel = 1'b0;
    int          wip_left = 0;
    int          busy_cfg = 0;
    int          n_wren = 0, n_write = 0, n_read = 0, n_rdsr = 0, n_bad = 0;
    logic [15:0] last_addr = '0;
    logic        wp_at_write = 1'b0;

    always @(posedge spi_sck or negedge spi_cs_n) begin
        if (!spi_sck) begin
            m_cnt <= 0;
            m_op  <= '0;
        end else begin
            m_shift <= {m_shift[30:0], spi_mosi};
            if (m_cnt == 7)  m_op   <= {m_shift[6:0], spi_mosi};
            if (m_cnt == 23) m_addr <= {m_shift[14:0], spi_mosi};
            m_cnt <= m_cnt + 1;
        end
    end

    always @(negedge spi_sck) begin
        if (!spi_cs_n) begin
            if (m_op == 8'h05 && m_cnt >= 8 && m_cnt < 16)
                spi_miso <= ({6'b0, wel, (wip_left > 0)} >> (15 - m_cnt)) & 1'b1;
            else if (m_op == 8'h03 && m_cnt >= 24 && m_cnt < 32)
                spi_miso <= mem[m_addr[7:0]][31 - m_cnt];
        end
    end

    always @(posedge spi_cs_n) begin
        if (m_cnt == 8 && m_shift[7:0] == 8'h06) begin
            wel <= 1'b1;
            n_wren <= n_wren + 1;
        end else if (m_cnt == 16 && m_shift[15:8] == 8'h05) begin
            n_rdsr <= n_rdsr + 1;
            if (wip_left > 0) wip_left <= wip_left - 1;
        end else if (m_cnt == 32 && m_shift[31:24] == 8'h02) begin
            n_write     <= n_write + 1;
            last_addr   <= m_shift[23:8];
            wp_at_write <= spi_wp_n;
            if (wel && spi_wp_n && wip_left == 0) begin
                mem[m_shift[15:8]] <= m_shift[7:0];
                wip_left <= busy_cfg;
            end
            wel <= 1'b0;
        end else if (m_cnt == 32 && m_shift[31:24] == 8'h03) begin
            n_read    <= n_read + 1;
            last_addr <= m_shift[23:8];
        end else if (rst_n) begin
            n_bad <= n_bad + 1;
        end
    end

    // ---------------- bus timing monitor ----------------
    logic prev_sck = 1'b0, prev_cs = 1'b1, seen_rise = 1'b0, gap_in_op = 1'b0;
    int   sck_run = 0, min_ph = 1000, max_ph = 0, cs_run = 0, min_gap = 1000;
    int   sck_cs_viol = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (spi_cs_n && spi_sck) sck_cs_viol <= sck_cs_viol + 1;
            if (spi_sck != prev_sck) begin
                if (prev_sck || seen_rise) begin
                    if (sck_run < min_ph) min_ph <= sck_run;
                    if (sck_run > max_ph) max_ph <= sck_run;
                end
                if (spi_sck) seen_rise <= 1'b1;
                sck_run <= 1;
            end else begin
                sck_run <= sck_run + 1;
            end
            if (spi_cs_n) seen_rise <= 1'b0;
            if (spi_cs_n != prev_cs) begin
                if (!spi_cs_n && gap_in_op && cs_run < min_gap) min_gap <= cs_run;
                if (spi_cs_n) gap_in_op <= 1'b1;
                cs_run <= 1;
            end else begin
                cs_run <= cs_run + 1;
                if (!busy) gap_in_op <= 1'b0;
            end
            prev_sck <= spi_sck;
            prev_cs  <= spi_cs_n;
        end
    end

    // ---------------- checking helpers ----------------
    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    endtask

    // Issue one request; returns after done is seen, with its width checked.
    task automatic run_op(input logic w, input logic [15:0] a, input logic [7:0] d,
                          input logic stray_req);
        int waited;
        @(negedge clk);
        req = 1'b1; we = w; addr = a; wdata = d;
        @(negedge clk);
        req = 1'b0;
        chk("R10 busy after take", busy, 1'b1);
        chk("R11 wp_n during request", spi_wp_n, w);
        if (stray_req) begin
            repeat (20) @(negedge clk);
            req = 1'b1; we = 1'b0; addr = 16'h5555; wdata = 8'h00;
            @(negedge clk);
            req = 1'b0;
        end
        waited = 0;
        while (!done && waited < 20000) begin
            @(negedge clk);
            waited++;
        end
        chk("R10 done seen", done, 1'b1);
        chk("R10 busy low at done", busy, 1'b0);
        @(negedge clk);
        chk("R10 done one cycle", done, 1'b0);
        chk("R11 wp_n low when idle", spi_wp_n, 1'b0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: run did not finish");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        repeat (4) @(negedge clk);
        // R1: reset values
        chk("R1 cs_n", spi_cs_n, 1'b1);
        chk("R1 sck", spi_sck, 1'b0);
        chk("R1 busy", busy, 1'b0);
        chk("R1 done", done, 1'b0);
        chk("R1 wp_n", spi_wp_n, 1'b0);
        chk("R1 timeout_err", timeout_err, 1'b0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // Vector table walk
        for (int i = 0; i < 6; i++) begin
            int w0, wr0, rd0, st0;
            w0 = n_wren; wr0 = n_write; rd0 = n_read; st0 = n_rdsr;
            busy_cfg = VEC[i].busy_replies;
            run_op(VEC[i].we, VEC[i].addr, VEC[i].data, 1'b0);
            chk("R9 no timeout", timeout_err, 1'b0);
            chk("R3 frame lengths", n_bad, 0);
            chk("R3 R5 address bits", last_addr, VEC[i].addr);
            if (VEC[i].we) begin
                chk("R3 enable frame", n_wren - w0, 1);
                chk("R3 write frame", n_write - wr0, 1);
                chk("R4 status polls", n_rdsr - st0, VEC[i].busy_replies + 1);
                chk("R11 wp_n at write", wp_at_write, 1'b1);
                chk("R3 stored byte", mem[VEC[i].addr[7:0]], VEC[i].data);
            end else begin
                chk("R5 read frame", n_read - rd0, 1);
                chk("R4 no polls on read", n_rdsr - st0, 0);
                chk("R5 rdata", rdata, VEC[i].data);
            end
        end

        // R2: a req pulse while busy is ignored
        begin
            int rd0, wr0;
            rd0 = n_read; wr0 = n_write;
            busy_cfg = 1;
            run_op(1'b1, 16'h0042, 8'h5A, 1'b1);
            repeat (200) @(negedge clk);
            chk("R2 no extra read", n_read - rd0, 0);
            chk("R2 single write", n_write - wr0, 1);
            chk("R2 busy stays idle", busy, 1'b0);
            run_op(1'b0, 16'h0042, 8'h00, 1'b0);
            chk("R2 R5 readback", rdata, 8'h5A);
        end

        // R6, R7, R8: bus timing observed over all frames so far
        chk("R6 sck low while deselected", sck_cs_viol, 0);
        chk("R7 shortest sck phase", min_ph, HALF_EXP);
        chk("R7 longest sck phase", max_ph, HALF_EXP);
        chk("R8 gap at least CS_GAP", (min_gap >= CS_GAP), 1'b1);

        // R9: device never clears its busy flag
        begin
            int st0;
            st0 = n_rdsr;
            busy_cfg = 100;
            run_op(1'b1, 16'h0077, 8'h11, 1'b0);
            chk("R9 timeout flagged", timeout_err, 1'b1);
            chk("R9 poll count", n_rdsr - st0, MAX_POLLS);
            repeat (5) @(negedge clk);
            chk("R9 timeout held", timeout_err, 1'b1);
            chk("R9 back to idle", busy, 1'b0);
        end

        finish_run();
    end
endmodule